// File: doc/BRIEF.md
# AXI4 Test Traffic Sequencer

This block is an AXI4 master that drives a run of test traffic into a slave. Software-independent configuration inputs select one of five sequencing modes, the transaction count, the address window, the ID, and the burst type, size and length. A `start` pulse launches the run and `done` rises when the run is complete. The five modes are write only, read only, writes and reads running concurrently, a write phase followed by a read-back phase, and per-write read-back interleaving.

Each burst carries a deterministic data pattern that is derived from its own start address. This lets the two read-back modes check every returned beat against the value that must have been written. In every mode, each channel spaces its address handshakes by a programmable number of idle cycles. A rate in MB/s is converted into that cycle count outside the block. In the interleaved mode, a small table indexed by ID holds the address of each write that has no response yet. A read is launched only when the write response for that ID arrives with an OKAY code.

Top module: `atg_traffic_seq`

## Requirements
- R1: After reset, and before any `start`, all AXI valid outputs are low, `done`, `chk_pass` and `chk_fail` are low, and `err_cnt` is 0.
- R2: Mode 0 (write only) issues exactly `cfg_count` write bursts and no read address. `done` rises after the last write response.
- R3: Mode 1 (read only) issues exactly `cfg_count` read bursts and no write address. `done` rises after the last read beat with `rlast`.
- R4: Mode 2 (parallel) runs both channels at once, with `cfg_count` writes and `cfg_count` reads.
- R5: Two successive write address handshakes are at least `cfg_wgap`+1 cycles apart. Two successive read address handshakes are at least `cfg_rgap`+1 cycles apart.
- R6: The first burst of each channel starts at `cfg_base`. Each following burst starts (`cfg_len`+1)<<`cfg_size` bytes later. When the following burst would end above `cfg_high`, the address returns to `cfg_base`. Every address lies in [`cfg_base`, `cfg_high`].
- R7: Mode 3 (write then read) issues no read address before all `cfg_count` write responses have arrived. It then reads the same address sequence as the write phase.
- R8: Mode 4 (interleaved) gives write k the ID k mod 2^IDW. It holds a write address whose ID still has an outstanding entry. It issues a read with the same ID to the address written under that ID, and only after an OKAY write response for that ID.
- R9: In mode 4, a write response that is not OKAY launches no read and adds 1 to `err_cnt`. In modes 3 and 4, a non-OKAY write response counts as an error.
- R10: In modes 3 and 4, `err_cnt` counts read beats whose data, `rresp` or `rid` differ from the expected values. When `done` is high, `chk_pass` is high if `err_cnt` is 0 and `chk_fail` is high otherwise. In modes 0, 1 and 2, both flags stay low and `err_cnt` stays 0, whatever data returns.
- R11: An asserted AW or AR valid stays high, with a stable address, until its ready is seen.
- R12: Every 32-bit lane of write beat b of a burst equals the burst start address plus b. `wlast` is high only on beat `cfg_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a run (ignored while busy) |
| cfg_mode | input | 3 | 0 write, 1 read, 2 parallel, 3 write-then-read, 4 interleaved |
| cfg_count | input | CW | Transactions per channel |
| cfg_base | input | AW | Lowest address |
| cfg_high | input | AW | Highest address |
| cfg_id | input | IDW | ID for modes 0 to 3 |
| cfg_burst | input | 2 | Burst type driven on AW/AR |
| cfg_size | input | 3 | log2 of bytes per beat |
| cfg_len | input | 8 | Beats minus one |
| cfg_wgap | input | GW | Idle cycles between write addresses |
| cfg_rgap | input | GW | Idle cycles between read addresses |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | AW | Write address |
| m_awid | output | IDW | Write ID |
| m_awlen | output | 8 | Write length |
| m_awsize | output | 3 | Write size |
| m_awburst | output | 2 | Write burst type |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | DW | Write data |
| m_wstrb | output | DW/8 | Write strobes (all set) |
| m_wlast | output | 1 | Last write beat |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready (always high) |
| m_bid | input | IDW | Write response ID |
| m_bresp | input | 2 | Write response code |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_araddr | output | AW | Read address |
| m_arid | output | IDW | Read ID |
| m_arlen | output | 8 | Read length |
| m_arsize | output | 3 | Read size |
| m_arburst | output | 2 | Read burst type |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready (always high) |
| m_rdata | input | DW | Read data |
| m_rid | input | IDW | Read ID |
| m_rresp | input | 2 | Read response code |
| m_rlast | input | 1 | Last read beat |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run complete, held until next start |
| chk_pass | output | 1 | Read-back found no error |
| chk_fail | output | 1 | Read-back found errors |
| err_cnt | output | CW | Error count |

## Verification
The checker watches several properties on every cycle. It checks that AW and AR hold their valid and address until ready and that write addresses are spaced by the write gap. It checks that write addresses stay inside the window and that `wlast` falls on beat `cfg_len`. It also checks that no read address appears in write-then-read mode before every write response is in, and that the pass and fail flags stay low outside a completed read-back run. The exact burst counts per mode, the wrap of the address sequence, the ID-matched read-back order, the skipped read after an error response and the error count after corrupted read data are shown only by the bench's scenarios. The bench checks these against its own model of the sequence.

// File: rtl/atg_pkg.sv
package atg_pkg;
    // Test sequencing modes; the encoding is the value of cfg_mode.
    typedef enum logic [2:0] {
        M_WR  = 3'd0,
        M_RD  = 3'd1,
        M_PAR = 3'd2,
        M_WTR = 3'd3,
        M_ILV = 3'd4
    } tmode_e;

    typedef enum logic [1:0] {WS_IDLE, WS_ADDR, WS_DATA} wst_e;
    typedef enum logic [1:0] {RS_IDLE, RS_ADDR, RS_DATA} rst_e;

    localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/atg_pace.sv
// Address pacing counter: after each handshake (fire), ok stays low for
// gap cycles, so two handshakes are at least gap+1 cycles apart.
// Assumes gap is stable during a run.
module atg_pace #(
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [GW-1:0] gap,
    output logic          ok
);
    logic [GW-1:0] cnt;

    // Load the gap on a handshake and count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (fire)         cnt <= gap;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign ok = (cnt == '0);
endmodule

// File: rtl/atg_astep.sv
// Next-burst address: advance by (len+1)<<size bytes. If the following
// burst would end above high, return to base. Assumes base+step-1 <= high.
module atg_astep #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] high,
    input  logic [7:0]    len,
    input  logic [2:0]    size,
    output logic [AW-1:0] nxt
);
    localparam int XW = AW + 2;
    logic [XW-1:0] step, cand, cend;

    // Compute the candidate address and its burst end with headroom bits.
    always_comb begin
        step = (XW'(len) + XW'(1)) << size;
        cand = XW'(addr) + step;
        cend = cand + step - XW'(1);
        nxt  = (cend > XW'(high)) ? base : cand[AW-1:0];
    end
endmodule

// File: rtl/atg_traffic_seq.sv
// AXI4 test traffic sequencer. Issues cfg_count bursts per active channel
// under one of five modes and checks read-back data in modes 3 and 4.
// Assumes cfg_* are stable from start until done, cfg_count >= 1, and the
// slave returns one read burst at a time in order.
module atg_traffic_seq
    import atg_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 64,
    parameter int IDW = 2,
    parameter int CW  = 20,
    parameter int GW  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       cfg_mode,
    input  logic [CW-1:0]    cfg_count,
    input  logic [AW-1:0]    cfg_base,
    input  logic [AW-1:0]    cfg_high,
    input  logic [IDW-1:0]   cfg_id,
    input  logic [1:0]       cfg_burst,
    input  logic [2:0]       cfg_size,
    input  logic [7:0]       cfg_len,
    input  logic [GW-1:0]    cfg_wgap,
    input  logic [GW-1:0]    cfg_rgap,
    output logic             m_awvalid,
    input  logic             m_awready,
    output logic [AW-1:0]    m_awaddr,
    output logic [IDW-1:0]   m_awid,
    output logic [7:0]       m_awlen,
    output logic [2:0]       m_awsize,
    output logic [1:0]       m_awburst,
    output logic             m_wvalid,
    input  logic             m_wready,
    output logic [DW-1:0]    m_wdata,
    output logic [DW/8-1:0]  m_wstrb,
    output logic             m_wlast,
    input  logic             m_bvalid,
    output logic             m_bready,
    input  logic [IDW-1:0]   m_bid,
    input  logic [1:0]       m_bresp,
    output logic             m_arvalid,
    input  logic             m_arready,
    output logic [AW-1:0]    m_araddr,
    output logic [IDW-1:0]   m_arid,
    output logic [7:0]       m_arlen,
    output logic [2:0]       m_arsize,
    output logic [1:0]       m_arburst,
    input  logic             m_rvalid,
    output logic             m_rready,
    input  logic [DW-1:0]    m_rdata,
    input  logic [IDW-1:0]   m_rid,
    input  logic [1:0]       m_rresp,
    input  logic             m_rlast,
    output logic             busy,
    output logic             done,
    output logic             chk_pass,
    output logic             chk_fail,
    output logic [CW-1:0]    err_cnt
);
    localparam int IDN   = 1 << IDW;
    localparam int LANES = DW / 32;

    tmode_e          mode_q;
    logic            run;
    wst_e            w_st;
    rst_e            r_st;
    logic [CW-1:0]   w_issued, b_cnt, r_issued, r_done, skip_cnt;
    logic [7:0]      w_beat, r_beat;
    logic [AW-1:0]   w_addr, w_nxt, r_seq, r_nxt, r_acur;
    logic [IDW-1:0]  w_id, r_idc, psel;
    logic [IDN-1:0]  tvalid, pend;
    logic [AW-1:0]   taddr [IDN];
    logic            w_ok, r_ok, aw_hs, ar_hs, start_go;
    logic            wr_en, rd_en, chk_en, ilv, rd_go, r_take;
    logic            r_bad, b_err, done_now;

    // Data pattern: every 32-bit lane is the burst address plus beat index.
    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a, input logic [7:0] b);
        for (int i = 0; i < LANES; i++) pat[i*32 +: 32] = 32'(a) + 32'(b);
    endfunction

    assign start_go = start && !run;
    assign ilv      = (mode_q == M_ILV);
    assign wr_en    = (mode_q != M_RD);
    assign rd_en    = (mode_q != M_WR);
    assign chk_en   = (mode_q == M_WTR) || ilv;
    assign w_id     = ilv ? w_issued[IDW-1:0] : cfg_id;
    assign aw_hs    = m_awvalid && m_awready;
    assign ar_hs    = m_arvalid && m_arready;

    assign m_awvalid = (w_st == WS_ADDR) && w_ok && !(ilv && tvalid[w_id]);
    assign m_awaddr  = w_addr;
    assign m_awid    = w_id;
    assign m_awlen   = cfg_len;
    assign m_awsize  = cfg_size;
    assign m_awburst = cfg_burst;
    assign m_wvalid  = (w_st == WS_DATA);
    assign m_wdata   = pat(w_addr, w_beat);
    assign m_wstrb   = '1;
    assign m_wlast   = (w_beat == cfg_len);
    assign m_bready  = 1'b1;
    assign m_arvalid = (r_st == RS_ADDR) && r_ok;
    assign m_araddr  = r_acur;
    assign m_arid    = r_idc;
    assign m_arlen   = cfg_len;
    assign m_arsize  = cfg_size;
    assign m_arburst = cfg_burst;
    assign m_rready  = 1'b1;
    assign busy      = run;

    atg_pace  #(.GW(GW)) u_wpace (.clk(clk), .rst_n(rst_n), .fire(aw_hs), .gap(cfg_wgap), .ok(w_ok));
    atg_pace  #(.GW(GW)) u_rpace (.clk(clk), .rst_n(rst_n), .fire(ar_hs), .gap(cfg_rgap), .ok(r_ok));
    atg_astep #(.AW(AW)) u_wstep (.addr(w_addr), .base(cfg_base), .high(cfg_high),
                                  .len(cfg_len), .size(cfg_size), .nxt(w_nxt));
    atg_astep #(.AW(AW)) u_rstep (.addr(r_seq), .base(cfg_base), .high(cfg_high),
                                  .len(cfg_len), .size(cfg_size), .nxt(r_nxt));

    // Lowest-numbered ID whose write was acknowledged and awaits its read.
    always_comb begin
        psel = '0;
        for (int i = IDN - 1; i >= 0; i--) if (pend[i]) psel = IDW'(i);
    end

    // Read launch condition per mode, read beat check and run completion.
    always_comb begin
        case (mode_q)
            M_RD, M_PAR: rd_go = (r_issued < cfg_count);
            M_WTR:       rd_go = (b_cnt == cfg_count) && (r_issued < cfg_count);
            M_ILV:       rd_go = |pend;
            default:     rd_go = 1'b0;
        endcase
        r_take   = run && (r_st == RS_IDLE) && rd_go;
        r_bad    = chk_en && m_rvalid && (r_st == RS_DATA) &&
                   ((m_rdata != pat(r_acur, r_beat)) || (m_rresp != RESP_OKAY) || (m_rid != r_idc));
        b_err    = chk_en && m_bvalid && (m_bresp != RESP_OKAY);
        done_now = run && (!wr_en || (w_st == WS_IDLE && b_cnt == cfg_count)) &&
                   (!rd_en || (r_st == RS_IDLE && (r_done + skip_cnt) == cfg_count));
    end

    // Run control: latch the mode at start, flag done when all channels finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0; done <= 1'b0; mode_q <= M_WR;
        end else if (start_go) begin
            run <= 1'b1; done <= 1'b0; mode_q <= tmode_e'(cfg_mode);
        end else if (done_now) begin
            run <= 1'b0; done <= 1'b1;
        end
    end

    // Write engine: address phase, then the data burst, then the next address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_st <= WS_IDLE; w_issued <= '0; w_beat <= '0; w_addr <= '0;
        end else if (start_go) begin
            w_issued <= '0;
            w_addr   <= cfg_base;
            w_st     <= (tmode_e'(cfg_mode) != M_RD) ? WS_ADDR : WS_IDLE;
        end else begin
            case (w_st)
                WS_ADDR: if (aw_hs) begin
                    w_st <= WS_DATA; w_beat <= '0; w_issued <= w_issued + 1'b1;
                end
                WS_DATA: if (m_wready) begin
                    w_beat <= w_beat + 1'b1;
                    if (m_wlast) begin
                        w_addr <= w_nxt;
                        w_st   <= (w_issued == cfg_count) ? WS_IDLE : WS_ADDR;
                    end
                end
                default: ;
            endcase
        end
    end

    // Read engine: pick the next target, issue its address, collect its beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_st <= RS_IDLE; r_issued <= '0; r_done <= '0; r_beat <= '0;
            r_seq <= '0; r_acur <= '0; r_idc <= '0;
        end else if (start_go) begin
            r_st <= RS_IDLE; r_issued <= '0; r_done <= '0; r_seq <= cfg_base;
        end else begin
            case (r_st)
                RS_IDLE: if (r_take) begin
                    r_st   <= RS_ADDR;
                    r_acur <= ilv ? taddr[psel] : r_seq;
                    r_idc  <= ilv ? psel : cfg_id;
                end
                RS_ADDR: if (ar_hs) begin
                    r_st <= RS_DATA; r_beat <= '0;
                    r_issued <= r_issued + 1'b1; r_seq <= r_nxt;
                end
                RS_DATA: if (m_rvalid) begin
                    r_beat <= r_beat + 1'b1;
                    if (m_rlast) begin
                        r_st <= RS_IDLE; r_done <= r_done + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Response bookkeeping: ID table, pending reads, response and error counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_cnt <= '0; skip_cnt <= '0; err_cnt <= '0; tvalid <= '0; pend <= '0;
            for (int i = 0; i < IDN; i++) taddr[i] <= '0;
        end else if (start_go) begin
            b_cnt <= '0; skip_cnt <= '0; err_cnt <= '0; tvalid <= '0; pend <= '0;
        end else begin
            if (aw_hs && ilv) begin
                tvalid[w_id] <= 1'b1;
                taddr[w_id]  <= w_addr;
            end
            if (r_take && ilv) begin
                pend[psel]   <= 1'b0;
                tvalid[psel] <= 1'b0;
            end
            if (m_bvalid) begin
                b_cnt <= b_cnt + 1'b1;
                if (ilv) begin
                    if (m_bresp == RESP_OKAY) pend[m_bid] <= 1'b1;
                    else begin
                        tvalid[m_bid] <= 1'b0;
                        skip_cnt      <= skip_cnt + 1'b1;
                    end
                end
            end
            err_cnt <= err_cnt + CW'(b_err) + CW'(r_bad);
        end
    end

    assign chk_pass = done && chk_en && (err_cnt == '0);
    assign chk_fail = done && chk_en && (err_cnt != '0);
endmodule

// File: rtl/atg_seq_chk.sv
// Protocol and sequencing checker bound to atg_traffic_seq.
module atg_seq_chk #(
    parameter int AW = 32,
    parameter int CW = 20,
    parameter int GW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          run,
    input logic [2:0]    mode,
    input logic [CW-1:0] cfg_count,
    input logic [AW-1:0] cfg_base,
    input logic [AW-1:0] cfg_high,
    input logic [GW-1:0] cfg_wgap,
    input logic [7:0]    cfg_len,
    input logic          m_awvalid,
    input logic          m_awready,
    input logic [AW-1:0] m_awaddr,
    input logic          m_wvalid,
    input logic          m_wready,
    input logic          m_wlast,
    input logic          m_bvalid,
    input logic          m_bready,
    input logic          m_arvalid,
    input logic          m_arready,
    input logic [AW-1:0] m_araddr,
    input logic          done,
    input logic          chk_pass,
    input logic          chk_fail
);
    logic [GW:0]   since;
    logic          seen;
    logic [CW-1:0] bseen;
    logic [7:0]    wb;

    // Cycles since the last write address handshake, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || (start && !run)) begin
            since <= '0; seen <= 1'b0;
        end else if (m_awvalid && m_awready) begin
            since <= '0; seen <= 1'b1;
        end else if (since != '1) begin
            since <= since + 1'b1;
        end
    end

    // Write responses received in the current run.
    always_ff @(posedge clk) begin
        if (!rst_n || (start && !run)) bseen <= '0;
        else if (m_bvalid && m_bready) bseen <= bseen + 1'b1;
    end

    // Beat index inside the current write burst.
    always_ff @(posedge clk) begin
        if (!rst_n) wb <= '0;
        else if (m_wvalid && m_wready) wb <= m_wlast ? 8'd0 : wb + 1'b1;
    end

    // R11
    aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr));
    // R11
    ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr));
    // R5
    aw_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid && m_awready && seen |-> since >= {1'b0, cfg_wgap});
    // R6
    aw_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid |-> (m_awaddr >= cfg_base) && (m_awaddr <= cfg_high));
    // R12
    wlast_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_wvalid && m_wready && m_wlast |-> wb == cfg_len);
    // R7
    wtr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && mode == 3'd3 && m_arvalid |-> bseen == cfg_count);
    // R10
    flag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done || (mode != 3'd3 && mode != 3'd4)) |-> !chk_pass && !chk_fail);
endmodule

bind atg_traffic_seq atg_seq_chk #(.AW(AW), .CW(CW), .GW(GW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .run(run), .mode(mode_q),
    .cfg_count(cfg_count), .cfg_base(cfg_base), .cfg_high(cfg_high),
    .cfg_wgap(cfg_wgap), .cfg_len(cfg_len),
    .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
    .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wlast(m_wlast),
    .m_bvalid(m_bvalid), .m_bready(m_bready),
    .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
    .done(done), .chk_pass(chk_pass), .chk_fail(chk_fail)
);

// File: tb/atg_traffic_seq_test.sv
`timescale 1ns/1ps
module atg_traffic_seq_test;
    localparam int AW = 32, DW = 64, IDW = 2, CW = 20, GW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic start = 1'b0;
    logic [2:0] cfg_mode = '0;
    logic [CW-1:0] cfg_count = 1;
    logic [AW-1:0] cfg_base = '0, cfg_high = 32'hFFF;
    logic [IDW-1:0] cfg_id = '0;
    logic [1:0] cfg_burst = 2'b01;
    logic [2:0] cfg_size = 3'd3;
    logic [7:0] cfg_len = '0;
    logic [GW-1:0] cfg_wgap = '0, cfg_rgap = '0;

    logic m_awvalid, m_awready = 1'b0, m_wvalid, m_wready = 1'b0, m_wlast;
    logic [AW-1:0] m_awaddr, m_araddr;
    logic [IDW-1:0] m_awid, m_arid, m_bid = '0, m_rid = '0;
    logic [7:0] m_awlen, m_arlen;
    logic [2:0] m_awsize, m_arsize;
    logic [1:0] m_awburst, m_arburst, m_bresp = '0, m_rresp = '0;
    logic [DW-1:0] m_wdata, m_rdata = '0;
    logic [DW/8-1:0] m_wstrb;
    logic m_bvalid = 1'b0, m_bready, m_arvalid, m_arready = 1'b0;
    logic m_rvalid = 1'b0, m_rready, m_rlast = 1'b0;
    logic busy, done, chk_pass, chk_fail;
    logic [CW-1:0] err_cnt;

    atg_traffic_seq #(.AW(AW), .DW(DW), .IDW(IDW), .CW(CW), .GW(GW)) uut (.*);

    int total = 0, bad = 0, cyc = 0;
    bit finished = 0;

    typedef struct packed { logic [IDW-1:0] id; logic [7:0] len; logic [AW-1:0] addr; } req_t;
    req_t aw_q[$], ar_q[$], rcur;
    logic [IDW-1:0] b_q[$];
    logic [DW-1:0] mem [logic [39:0]];

    int aw_n, ar_n, b_n, addr_err, wd_err, ord_err, gap_err, hold_err;
    int wbeat, rbeat, r_act, rbeat_g, bad_b_at, bad_r_at, last_aw, last_ar;
    logic [AW-1:0] wexp, rexp, idaddr [4];
    bit bok [4];
    logic pv_aw, pv_ar;
    logic [AW-1:0] pa_aw, pa_ar;

    function automatic logic [DW-1:0] expat(input logic [AW-1:0] a, input int b);
        for (int i = 0; i < DW/32; i++) expat[i*32 +: 32] = a + 32'(b);
    endfunction

    function automatic logic [AW-1:0] nexta(input logic [AW-1:0] a);
        longint step = longint'(cfg_len + 1) << cfg_size;
        longint c = longint'(a) + step;
        if (c + step - 1 > longint'(cfg_high)) return cfg_base;
        return AW'(c);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Slave model and monitor: responders use nonblocking updates to DUT inputs.
    always @(posedge clk) begin
        if (rst_n) begin
            if (pv_aw && !(m_awvalid && m_awaddr == pa_aw)) hold_err++;
            if (pv_ar && !(m_arvalid && m_araddr == pa_ar)) hold_err++;
            pv_aw = m_awvalid && !m_awready; pa_aw = m_awaddr;
            pv_ar = m_arvalid && !m_arready; pa_ar = m_araddr;
            if (m_awvalid && m_awready) begin
                if (aw_n > 0 && cyc - last_aw < int'(cfg_wgap) + 1) gap_err++;
                last_aw = cyc;
                if (m_awaddr != wexp) addr_err++;
                wexp = nexta(wexp);
                idaddr[m_awid] = m_awaddr; bok[m_awid] = 0;
                aw_q.push_back({m_awid, m_awlen, m_awaddr});
                aw_n++;
            end
            if (m_wvalid && m_wready) begin
                if (m_wdata != expat(aw_q[0].addr, wbeat) || m_wlast != (wbeat == int'(aw_q[0].len))) wd_err++;
                mem[{aw_q[0].addr, 8'(wbeat)}] = m_wdata;
                wbeat++;
                if (m_wlast) begin b_q.push_back(aw_q[0].id); void'(aw_q.pop_front()); wbeat = 0; end
            end
            if (m_bvalid) begin
                if (m_bresp == 2'b00) bok[m_bid] = 1;
                b_n++;
            end
            m_bvalid <= 1'b0;
            if (b_q.size() > 0 && ($urandom % 2) == 0) begin
                m_bvalid <= 1'b1;
                m_bid <= b_q.pop_front();
                m_bresp <= (b_n + (m_bvalid ? 0 : 0) == bad_b_at) ? 2'b10 : 2'b00;
            end
            if (m_arvalid && m_arready) begin
                if (ar_n > 0 && cyc - last_ar < int'(cfg_rgap) + 1) gap_err++;
                last_ar = cyc;
                if (cfg_mode == 3'd4) begin
                    if (!bok[m_arid] || m_araddr != idaddr[m_arid]) ord_err++;
                    bok[m_arid] = 0;
                end else begin
                    if (cfg_mode == 3'd3 && b_n < int'(cfg_count)) ord_err++;
                    if (m_araddr != rexp) addr_err++;
                    rexp = nexta(rexp);
                end
                ar_q.push_back({m_arid, m_arlen, m_araddr});
                ar_n++;
            end
            if (m_rvalid) begin
                rbeat++; rbeat_g++;
                if (m_rlast) r_act = 0;
            end
            m_rvalid <= 1'b0;
            if (r_act == 0 && ar_q.size() > 0) begin rcur = ar_q.pop_front(); r_act = 1; rbeat = 0; end
            if (r_act == 1 && ($urandom % 4) != 0) begin
                logic [39:0] k = {rcur.addr, 8'(rbeat)};
                m_rvalid <= 1'b1;
                m_rdata <= (mem.exists(k) ? mem[k] : expat(rcur.addr, rbeat)) ^ ((rbeat_g == bad_r_at) ? 64'd1 : 64'd0);
                m_rlast <= (rbeat == int'(rcur.len));
                m_rid <= rcur.id;
                m_rresp <= 2'b00;
            end
            m_awready <= ($urandom % 4) != 0;
            m_wready  <= ($urandom % 4) != 0;
            m_arready <= ($urandom % 4) != 0;
        end
    end

    task automatic run_case(input int mode, input int n, input logic [AW-1:0] base, input logic [AW-1:0] high,
                            input int len, input int size, input int wg, input int rg,
                            input int bb, input int br);
        bit chkm = (mode == 3 || mode == 4);
        int exp_aw, exp_ar, exp_err, w;
        string tg;
        @(negedge clk);
        cfg_mode = 3'(mode); cfg_count = CW'(n); cfg_base = base; cfg_high = high;
        cfg_len = 8'(len); cfg_size = 3'(size); cfg_wgap = GW'(wg); cfg_rgap = GW'(rg);
        cfg_id = 2'd1; cfg_burst = 2'b01;
        aw_n = 0; ar_n = 0; b_n = 0; addr_err = 0; wd_err = 0; ord_err = 0; gap_err = 0; hold_err = 0;
        rbeat_g = 0; bad_b_at = bb; bad_r_at = br; wexp = base; rexp = base;
        for (int i = 0; i < 4; i++) bok[i] = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        w = 0;
        while (!done && w < 40000) begin @(negedge clk); w++; end
        tg = (mode == 0) ? "R2" : (mode == 1) ? "R3" : (mode == 2) ? "R4" : (mode == 3) ? "R7" : "R8";
        exp_aw = (mode == 1) ? 0 : n;
        exp_ar = (mode == 0) ? 0 : ((mode == 4 && bb >= 0) ? n - 1 : n);
        exp_err = chkm ? ((bb >= 0 ? 1 : 0) + (br >= 0 ? 1 : 0)) : 0;
        chk(done == 1'b1, {tg, " done"}, done, 1);
        chk(aw_n == exp_aw, {tg, " write bursts"}, aw_n, exp_aw);
        chk(ar_n == exp_ar, {tg, " read bursts"}, ar_n, exp_ar);
        chk(addr_err == 0, "R6 address sequence", addr_err, 0);
        chk(wd_err == 0, "R12 write data/wlast", wd_err, 0);
        chk(gap_err == 0, "R5 address spacing", gap_err, 0);
        chk(hold_err == 0, "R11 valid hold", hold_err, 0);
        chk(ord_err == 0, (mode == 4) ? "R8 read-back order" : "R7 read-after-responses", ord_err, 0);
        chk(int'(err_cnt) == exp_err, (bb >= 0 && mode == 4) ? "R9 error count" : "R10 error count", err_cnt, exp_err);
        chk(chk_pass == (chkm && exp_err == 0), "R10 pass flag", chk_pass, chkm && exp_err == 0);
        chk(chk_fail == (chkm && exp_err != 0), "R10 fail flag", chk_fail, chkm && exp_err != 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL R2 watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        pv_aw = 0; pv_ar = 0; r_act = 0; rbeat = 0; wbeat = 0; bad_b_at = -1; bad_r_at = -1;
        aw_n = 0; ar_n = 0; b_n = 0; last_aw = 0; last_ar = 0; rbeat_g = 0;
        repeat (4) @(negedge clk);
        chk(!m_awvalid && !m_arvalid && !m_wvalid && !done && !chk_pass && !chk_fail && err_cnt == 0,
            "R1 reset state", {m_awvalid, m_arvalid, m_wvalid, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!m_awvalid && !m_arvalid && !done && err_cnt == 0, "R1 idle after reset", {m_awvalid, m_arvalid, done}, 0);
        // Directed: each mode, wrap corner, corrupted read in non-check mode (R10 ignored).
        run_case(0, 6, 32'h1000, 32'h103F, 1, 3, 3, 0, -1, -1);
        run_case(1, 5, 32'h2000, 32'h2FFF, 3, 2, 0, 4, -1, 2);
        run_case(2, 7, 32'h3000, 32'h305F, 2, 3, 1, 2, -1, -1);
        run_case(3, 5, 32'h4000, 32'h407F, 3, 3, 0, 0, -1, -1);
        run_case(3, 4, 32'h5000, 32'h503F, 1, 3, 2, 1, -1, 3);
        run_case(4, 9, 32'h6000, 32'h60FF, 1, 3, 0, 0, -1, -1);
        run_case(4, 8, 32'h7000, 32'h70FF, 0, 3, 1, 0, 3, -1);
        run_case(0, 2, 32'h8000, 32'h8FFF, 255, 3, 0, 0, -1, -1);
        // Random configurations.
        for (int t = 0; t < 10; t++) begin
            int md = $urandom % 5, ln = $urandom % 8, sz = $urandom % 4;
            int st = (ln + 1) << sz;
            int sl = 2 + $urandom % 4;
            logic [AW-1:0] bs = 32'h10000 + 32'(t) * 32'h1000;
            run_case(md, 1 + $urandom % 10, bs, bs + 32'(sl * st - 1 + ($urandom % st)),
                     ln, sz, $urandom % 5, $urandom % 5, -1, -1);
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule